// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the general register file of a 32-bit processor core. It has sixteen logical registers, and where each one is physically stored depends on the processor mode. Registers 0 to 7 are one set of storage seen from every mode. Registers 8 to 12 get a second copy that only the fast-interrupt mode uses. Registers 13 (stack pointer) and 14 (link register) get a private pair in each mode that is entered through an exception. Register 15 is the program counter. It is held in its own register, which either steps forward or is loaded by a write.

Two combinational read ports and one write port all use the same 4-bit logical numbering. The mode input selects the bank for all three ports. Privileged code can set a user-bank override so that registers 8 to 14 reach the user copies. A write is decoded with the mode and override that are present at the clock edge that performs it. There is no bypass from the write port to the read ports. The surrounding core owns mode changes, arithmetic and memory access.

Top module: `mreg_bank_file`

## Requirements
- R1: Logical registers 0 to 7 are one storage set in every mode. A value written in any mode, with or without the override, reads back the same in all modes.
- R2: Registers 8 to 12 have a separate copy used only in fast-interrupt mode (mode code 1) with the override clear. Every other mode code uses the user copies.
- R3: Registers 13 and 14 have a private copy for each of the mode codes fast-interrupt 1, interrupt 2, supervisor 3, abort 4 and undefined 5. User (0), system (6) and the unused code 7 all use the user copies.
- R4: While `user_bank_i` is 1, reads and writes of registers 8 to 14 use the user copies whatever the mode. The banked copies are left unchanged.
- R5: A read of register 15 on either port returns the current program counter plus 8.
- R6: A write to register 15 loads the program counter at that edge, taking priority over `pc_adv_i`. `flush_o` is 1 during the following cycle only and is 0 at all other times.
- R7: With `pc_adv_i` at 1 and no write to register 15, the program counter rises by 4 at each edge.
- R8: A write is decoded with the `mode_i` and `user_bank_i` values present at the edge that performs it.
- R9: A read of a register that is being written in the same cycle returns the old value. The new value is readable from the next cycle on.
- R10: After a synchronous reset every register reads 0, the program counter is 0 and `flush_o` is 0.
- R11: The two read ports are independent, so different registers can be read from them in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Mode code 0 to 7 (see R2, R3) |
| user_bank_i | input | 1 | Route registers 8 to 14 to the user copies |
| rd_a_addr_i | input | 4 | Logical register for read port A |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_addr_i | input | 4 | Logical register for read port B |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 4 | Logical register to write |
| wr_data_i | input | 32 | Write data |
| pc_adv_i | input | 1 | Step the program counter |
| pc_o | output | 32 | Current program counter |
| flush_o | output | 1 | One-cycle strobe after a program counter load |

## Verification
The read-back properties assume that `mode_i` and `user_bank_i` stay the same between the write and the following read. They claim nothing when either one changes, because distinct mode codes may share a copy. The program counter properties assume that no reset happens in the middle of a write. The bench changes inputs only just after a clock edge, holds the mode steady across every write and read-back pair, and asserts reset only at the start of the run.

// File: rtl/mrb_pkg.sv
// Package: mode codes and physical-slot layout of the banked register file.
// Assumes a 16-entry logical file with register 15 kept outside the array.
package mrb_pkg;
    typedef enum logic [2:0] {
        MD_USER   = 3'd0,
        MD_FAST   = 3'd1,
        MD_INTR   = 3'd2,
        MD_SUPV   = 3'd3,
        MD_ABORT  = 3'd4,
        MD_UNDEF  = 3'd5,
        MD_SYSTEM = 3'd6,
        MD_RSVD   = 3'd7
    } bank_mode_e;

    localparam int LOG_REGS   = 16;
    localparam int LREG_W     = $clog2(LOG_REGS);
    localparam int PC_REG     = 15;
    localparam int SHARED_TOP = 7;
    localparam int FAST_LO    = 8;
    localparam int FAST_HI    = 12;
    localparam int SP_REG     = 13;
    localparam int USER_SLOTS = PC_REG;
    localparam int FAST_SLOTS = FAST_HI - FAST_LO + 1;
    localparam int EXC_MODES  = 5;
    localparam int EXC_BASE   = USER_SLOTS + FAST_SLOTS;
    localparam int PHYS_SLOTS = EXC_BASE + 2 * EXC_MODES;
    localparam int PIDX_W     = $clog2(PHYS_SLOTS);
endpackage

// File: rtl/mrb_map.sv
// Module: maps a logical register number to a physical slot for a mode.
// Assumes the slot layout of mrb_pkg: user copies first, then the
// fast-interrupt copies of 8..12, then one 13/14 pair per exception mode.
module mrb_map
    import mrb_pkg::*;
(
    input  logic [2:0]        mode_i,
    input  logic              user_bank_i,
    input  logic [LREG_W-1:0] lreg_i,
    output logic [PIDX_W-1:0] pidx_o,
    output logic              is_pc_o
);
    bank_mode_e mode;
    int         lr;
    int         exc_k;
    int         slot;

    assign mode = bank_mode_e'(mode_i);
    assign lr   = int'(lreg_i);

    // Purpose: index of the private 13/14 pair for the mode, -1 if none.
    always_comb begin
        case (mode)
            MD_FAST:  exc_k = 0;
            MD_INTR:  exc_k = 1;
            MD_SUPV:  exc_k = 2;
            MD_ABORT: exc_k = 3;
            MD_UNDEF: exc_k = 4;
            default:  exc_k = -1;
        endcase
    end

    // Purpose: choose the physical slot from the register group and the bank.
    always_comb begin
        slot    = lr;
        is_pc_o = 1'b0;
        if (lr == PC_REG) begin
            is_pc_o = 1'b1;
            slot    = 0;
        end else if (lr <= SHARED_TOP) begin
            slot = lr;
        end else if (lr <= FAST_HI) begin
            if (mode == MD_FAST && !user_bank_i)
                slot = USER_SLOTS + (lr - FAST_LO);
        end else begin
            if (!user_bank_i && exc_k >= 0)
                slot = EXC_BASE + 2 * exc_k + (lr - SP_REG);
        end
        pidx_o = PIDX_W'(slot);
    end
endmodule

// File: rtl/mrb_store.sv
// Module: physical register storage with two combinational reads and one
// synchronous write. Assumes slot indices come from mrb_map (below DEPTH).
module mrb_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 30,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  widx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  ra_idx_i,
    input  logic [IDX_W-1:0]  rb_idx_i,
    output logic [DATA_W-1:0] ra_data_o,
    output logic [DATA_W-1:0] rb_data_o
);
    logic [DATA_W-1:0] slots [DEPTH];

    // Purpose: clear every slot on reset, otherwise write one slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else if (we_i && int'(widx_i) < DEPTH) begin
            slots[widx_i] <= wdata_i;
        end
    end

    // Purpose: read both ports with no write bypass (old value on collision).
    always_comb begin
        ra_data_o = (int'(ra_idx_i) < DEPTH) ? slots[ra_idx_i] : '0;
        rb_data_o = (int'(rb_idx_i) < DEPTH) ? slots[rb_idx_i] : '0;
    end
endmodule

// File: rtl/mrb_pc.sv
// Module: program counter register. A load takes priority over a step,
// and a registered strobe marks the cycle after each load.
module mrb_pc #(
    parameter int          DATA_W   = 32,
    parameter int          PC_STEP  = 4,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_val_i,
    input  logic              adv_i,
    output logic [DATA_W-1:0] pc_o,
    output logic              flush_o
);
    // Purpose: load, step or hold the program counter.
    always_ff @(posedge clk) begin
        if (!rst_n)      pc_o <= DATA_W'(RESET_PC);
        else if (load_i) pc_o <= load_val_i;
        else if (adv_i)  pc_o <= pc_o + DATA_W'(PC_STEP);
    end

    // Purpose: raise the flush strobe for exactly the cycle after a load.
    always_ff @(posedge clk) begin
        if (!rst_n) flush_o <= 1'b0;
        else        flush_o <= load_i;
    end
endmodule

// File: rtl/mreg_bank_file.sv
// Module: mode-banked 16 x 32 register file, top level. Three address maps
// (two reads, one write) share the current mode and override. Register 15
// goes to the program counter unit, and reads of it return pc + PC_READ_OFS.
// Assumes the core keeps mode_i stable and valid around each access.
module mreg_bank_file
    import mrb_pkg::*;
#(
    parameter int          DATA_W      = 32,
    parameter int          PC_STEP     = 4,
    parameter int          PC_READ_OFS = 8,
    parameter logic [31:0] RESET_PC    = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic              user_bank_i,
    input  logic [3:0]        rd_a_addr_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    input  logic [3:0]        rd_b_addr_i,
    output logic [DATA_W-1:0] rd_b_data_o,
    input  logic              wr_en_i,
    input  logic [3:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              pc_adv_i,
    output logic [DATA_W-1:0] pc_o,
    output logic              flush_o
);
    localparam int NPORTS = 3;  // 0: read A, 1: read B, 2: write

    logic [LREG_W-1:0] port_addr [NPORTS];
    logic [PIDX_W-1:0] port_pidx [NPORTS];
    logic              port_pc   [NPORTS];
    logic [DATA_W-1:0] st_a, st_b, pc_view;

    assign port_addr[0] = rd_a_addr_i;
    assign port_addr[1] = rd_b_addr_i;
    assign port_addr[2] = wr_addr_i;

    // One address map per port, all fed with the current mode.
    for (genvar p = 0; p < NPORTS; p++) begin : g_map
        mrb_map u_map (
            .mode_i      (mode_i),
            .user_bank_i (user_bank_i),
            .lreg_i      (port_addr[p]),
            .pidx_o      (port_pidx[p]),
            .is_pc_o     (port_pc[p])
        );
    end

    mrb_store #(.DATA_W(DATA_W), .DEPTH(PHYS_SLOTS), .IDX_W(PIDX_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (wr_en_i && !port_pc[2]),
        .widx_i    (port_pidx[2]),
        .wdata_i   (wr_data_i),
        .ra_idx_i  (port_pidx[0]),
        .rb_idx_i  (port_pidx[1]),
        .ra_data_o (st_a),
        .rb_data_o (st_b)
    );

    mrb_pc #(.DATA_W(DATA_W), .PC_STEP(PC_STEP), .RESET_PC(RESET_PC)) u_pc (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (wr_en_i && port_pc[2]),
        .load_val_i (wr_data_i),
        .adv_i      (pc_adv_i),
        .pc_o       (pc_o),
        .flush_o    (flush_o)
    );

    assign pc_view = pc_o + DATA_W'(PC_READ_OFS);

    // Purpose: steer each read port to the store or to the offset counter.
    always_comb begin
        rd_a_data_o = port_pc[0] ? pc_view : st_a;
        rd_b_data_o = port_pc[1] ? pc_view : st_b;
    end
endmodule

// File: rtl/mreg_bank_file_chk.sv
// Module: assertion checker for mreg_bank_file, attached by bind.
// Assumes mode and override are held between a write and its read-back.
module mreg_bank_file_chk #(
    parameter int DATA_W      = 32,
    parameter int PC_STEP     = 4,
    parameter int PC_READ_OFS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        mode_i,
    input logic              user_bank_i,
    input logic [3:0]        rd_a_addr_i,
    input logic [DATA_W-1:0] rd_a_data_o,
    input logic [3:0]        rd_b_addr_i,
    input logic [DATA_W-1:0] rd_b_data_o,
    input logic              wr_en_i,
    input logic [3:0]        wr_addr_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              pc_adv_i,
    input logic [DATA_W-1:0] pc_o,
    input logic              flush_o
);
    logic wr_pc;
    assign wr_pc = wr_en_i && (wr_addr_i == 4'd15);

    AST_LOW_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i < 4'd8) |=> (rd_a_addr_i != $past(wr_addr_i) || rd_a_data_o == $past(wr_data_i))); // R1
    AST_SAME_BANK_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_pc) |=> (rd_b_addr_i != $past(wr_addr_i) || mode_i != $past(mode_i) || user_bank_i != $past(user_bank_i) || rd_b_data_o == $past(wr_data_i))); // R8
    AST_PC_READ_OFS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr_i == 4'd15) |-> (rd_a_data_o == pc_o + DATA_W'(PC_READ_OFS))); // R5
    AST_PC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pc |=> (pc_o == $past(wr_data_i) && flush_o)); // R6
    AST_NO_STRAY_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pc |=> !flush_o); // R6
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_adv_i && !wr_pc) |=> (pc_o == $past(pc_o) + DATA_W'(PC_STEP))); // R7
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_adv_i && !wr_pc) |=> $stable(pc_o)); // R7
endmodule

bind mreg_bank_file mreg_bank_file_chk #(
    .DATA_W(DATA_W), .PC_STEP(PC_STEP), .PC_READ_OFS(PC_READ_OFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .user_bank_i(user_bank_i),
    .rd_a_addr_i(rd_a_addr_i), .rd_a_data_o(rd_a_data_o),
    .rd_b_addr_i(rd_b_addr_i), .rd_b_data_o(rd_b_data_o),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .pc_adv_i(pc_adv_i), .pc_o(pc_o), .flush_o(flush_o)
);

// File: tb/mreg_bank_file_bench.sv
// Directed bench for mreg_bank_file: one task per scenario.
module mreg_bank_file_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_i = 3'd0;
    logic        user_bank_i = 1'b0;
    logic [3:0]  rd_a_addr_i = 4'd0, rd_b_addr_i = 4'd0, wr_addr_i = 4'd0;
    logic [31:0] rd_a_data_o, rd_b_data_o, wr_data_i = 32'h0, pc_o;
    logic        wr_en_i = 1'b0, pc_adv_i = 1'b0, flush_o;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    mreg_bank_file u_mreg_bank_file (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] m, input logic ub, input logic [3:0] a, input logic [31:0] d);
        mode_i = m; user_bank_i = ub; wr_addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
        tick();
        wr_en_i = 1'b0;
    endtask

    task automatic rda(input logic [2:0] m, input logic ub, input logic [3:0] a,
                       input logic [31:0] exp, input string req);
        mode_i = m; user_bank_i = ub; rd_a_addr_i = a;
        #2;
        check(req, rd_a_data_o, exp);
    endtask

    task automatic t_reset();  // R10
        for (int r = 0; r < 15; r += 7) rda(3'd0, 1'b0, 4'(r), 32'h0, "R10 reg after reset");
        rda(3'd3, 1'b0, 4'd13, 32'h0, "R10 banked sp after reset");
        check("R10 pc after reset", pc_o, 32'h0);
        check("R10 flush after reset", {31'h0, flush_o}, 32'h0);
    endtask

    task automatic t_low_shared();  // R1
        wr(3'd3, 1'b0, 4'd3, 32'hA5A5_0003);
        wr(3'd1, 1'b1, 4'd7, 32'h0000_0777);
        for (int m = 0; m < 8; m++) rda(3'(m), 1'b0, 4'd3, 32'hA5A5_0003, "R1 r3 shared");
        rda(3'd1, 1'b0, 4'd7, 32'h0000_0777, "R1 r7 shared");
    endtask

    task automatic t_fast_bank();  // R2
        wr(3'd0, 1'b0, 4'd9, 32'h0000_0A09);
        wr(3'd1, 1'b0, 4'd9, 32'h0000_0B09);
        wr(3'd1, 1'b0, 4'd12, 32'h0000_0B12);
        rda(3'd0, 1'b0, 4'd9, 32'h0000_0A09, "R2 user r9");
        rda(3'd1, 1'b0, 4'd9, 32'h0000_0B09, "R2 fast r9");
        rda(3'd2, 1'b0, 4'd9, 32'h0000_0A09, "R2 intr r9 uses user");
        rda(3'd6, 1'b0, 4'd9, 32'h0000_0A09, "R2 system r9 uses user");
        rda(3'd0, 1'b0, 4'd12, 32'h0, "R2 user r12 untouched");
    endtask

    task automatic t_sp_bank();  // R3
        for (int m = 0; m < 7; m++) wr(3'(m), 1'b0, 4'd13, 32'h1300 + 32'(m));
        for (int m = 1; m < 6; m++) rda(3'(m), 1'b0, 4'd13, 32'h1300 + 32'(m), "R3 private sp");
        rda(3'd0, 1'b0, 4'd13, 32'h1306, "R3 user sp shared with system");
        rda(3'd7, 1'b0, 4'd13, 32'h1306, "R3 code 7 uses user sp");
        wr(3'd3, 1'b0, 4'd14, 32'h0000_1403);
        rda(3'd4, 1'b0, 4'd14, 32'h0, "R3 abort lr unaffected by supervisor write");
        rda(3'd3, 1'b0, 4'd14, 32'h0000_1403, "R3 supervisor lr");
    endtask

    task automatic t_override();  // R4
        wr(3'd1, 1'b1, 4'd10, 32'h0000_0C10);
        rda(3'd0, 1'b0, 4'd10, 32'h0000_0C10, "R4 override write reaches user r10");
        rda(3'd1, 1'b0, 4'd10, 32'h0, "R4 fast r10 untouched");
        rda(3'd3, 1'b1, 4'd13, 32'h1306, "R4 override read of user sp");
        wr(3'd3, 1'b1, 4'd14, 32'h0000_0E14);
        rda(3'd0, 1'b0, 4'd14, 32'h0000_0E14, "R4 override write reaches user lr");
        rda(3'd3, 1'b0, 4'd14, 32'h0000_1403, "R4 supervisor lr untouched");
    endtask

    task automatic t_mode_edge();  // R8
        mode_i = 3'd3;
        tick();
        wr(3'd4, 1'b0, 4'd13, 32'h0000_5504);
        rda(3'd4, 1'b0, 4'd13, 32'h0000_5504, "R8 write uses mode at edge");
        rda(3'd3, 1'b0, 4'd13, 32'h1303, "R8 earlier mode bank untouched");
    endtask

    task automatic t_collision();  // R9, R11
        mode_i = 3'd0; user_bank_i = 1'b0;
        rd_a_addr_i = 4'd5; rd_b_addr_i = 4'd9;
        wr_addr_i = 4'd5; wr_data_i = 32'hDEAD_0005; wr_en_i = 1'b1;
        #2;
        check("R9 old value during write", rd_a_data_o, 32'h0);
        check("R11 port b independent", rd_b_data_o, 32'h0000_0A09);
        tick();
        wr_en_i = 1'b0;
        #2;
        check("R9 new value after edge", rd_a_data_o, 32'hDEAD_0005);
    endtask

    task automatic t_pc();  // R5, R6, R7
        rd_b_addr_i = 4'd15;
        rda(3'd0, 1'b0, 4'd15, 32'h8, "R5 read pc+8");
        pc_adv_i = 1'b1;
        tick(); tick(); tick();
        check("R7 pc after 3 steps", pc_o, 32'hC);
        check("R5 port b pc+8", rd_b_data_o, 32'h14);
        check("R6 no flush while stepping", {31'h0, flush_o}, 32'h0);
        wr(3'd0, 1'b0, 4'd15, 32'h0000_0100);
        check("R6 load beats step", pc_o, 32'h100);
        check("R6 flush after load", {31'h0, flush_o}, 32'h1);
        pc_adv_i = 1'b0;
        tick();
        check("R6 flush one cycle only", {31'h0, flush_o}, 32'h0);
        check("R7 pc holds", pc_o, 32'h100);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #2;
        t_reset();
        t_low_shared();
        t_fast_bank();
        t_sp_bank();
        t_override();
        t_mode_edge();
        t_collision();
        t_pc();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule